// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block keeps the per-interrupt state of a distributor that routes interrupt lines to several processors, and makes that state visible through a byte-wide register port. Each interrupt has an enable bit, a pending bit, an active bit, an 8-bit priority, an 8-bit processor target mask and a 2-bit configuration field. The bank also keeps one global enable bit and returns a set of fixed identification bytes.

Software, or a bus adapter placed in front of this block, makes one access per cycle. It presents an address, a write strobe and a data byte. Read data and the error flag appear in the cycle after the access. Enable and pending state each have two address windows over the same bits: one window sets bits and the other clears them. Active state for low-numbered internal interrupts is kept separately for each processor, and a processor index input chooses which copy is seen and written.

Top module: `irq_dist_regbank`

## Requirements
- R1: After reset every enable, pending, active, priority, target and configuration value is zero, the global enable is zero, and `rdata` and `err` are zero.
- R2: Address 0x000 reads the global enable in bit 0, and a write there stores `wdata[0]`. Address 0x004 reads NUM_IRQ/32-1. Addresses 0x001-0x003 and 0x005-0x007 read zero and ignore writes. Every other address below 0x100 is an error.
- R3: Enable bits are read at both 0x100+k and 0x180+k, where bit i of byte k is interrupt 8k+i. Writing a 1 to a bit in the lower window sets that enable bit. Writing a 1 in the upper window clears it. Bits written as 0 are left unchanged.
- R4: Pending bits use the same byte and bit packing and the same set/clear behaviour, with the set window at 0x200+k and the clear window at 0x280+k.
- R5: Byte 0x300+k holds the active bits of interrupts 8k..8k+7. A write stores the whole byte. For interrupts below NUM_INTERNAL, the bit that is read or written belongs to the processor given by `cpu_sel`. Interrupts at or above NUM_INTERNAL share one bit across all processors.
- R6: Byte 0x400+n is the priority of interrupt n, and byte 0x800+n is its target mask. Both can be read and written as whole bytes.
- R7: Byte 0xC00+k covers interrupts 4k..4k+3. Bit 2j is the model bit and bit 2j+1 is the trigger bit of interrupt 4k+j. Both can be read and written.
- R8: An access to an enable, pending, active, priority, target or configuration window whose first computed interrupt number is NUM_IRQ or more is an error, and so is any access to 0xF00-0xFDF. An erroring access changes no state and returns zero data.
- R9: A read at 0xFE0+4k returns identification byte k, which is `ID_VALUE[8k+7:8k]`. Non-aligned addresses from 0xFE0 up read zero. Writes anywhere from 0xFE0 up are ignored and raise no error.
- R10: `rdata` and `err` are registered, so an access at one rising edge shows its result after that edge. `err` is high for exactly that one cycle for each erroring access. `rdata` is zero after writes, after idle cycles and after errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sel | input | CPU_W | Processor whose banked active bits are accessed |
| acc_en | input | 1 | An access is made this cycle |
| wr_en | input | 1 | The access is a write |
| addr | input | 12 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the previous cycle's access |
| err | output | 1 | The previous cycle's access was undecoded or out of range |

## Verification
The bench probes the last valid byte and the first out-of-range byte of every window. A design that computes interrupt numbers with the wrong packing density would either flag a valid byte as an error or alias a real register. The bench writes active bits under one processor index and reads them under the other, on both sides of the internal limit. If the banking were missing, internal bits would leak between processors. If it were applied to every interrupt, shared bits would seem to vanish. Writes through the clear window followed by reads through the set window would reveal windows that do not share storage or that treat written zeros as clears. Unaligned and write accesses to the identification range must read zero and raise no error.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   localparam int ADDR_W = 12;
   localparam int IDX_W  = 13;

   typedef enum logic [3:0] {
      W_GEN, W_TYPE, W_ZERO, W_EN, W_PEND, W_ACT,
      W_PRIO, W_TGT, W_CFG, W_ID, W_BAD
   } win_e;

   typedef struct packed {
      win_e             win;
      logic             clr;
      logic [IDX_W-1:0] base;
      logic [2:0]       idsel;
   } dec_t;
endpackage

// File: rtl/irqd_decode.sv
module irqd_decode
   import irqd_pkg::*;
#(
   parameter int NUM_IRQ = 96
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   logic [ADDR_W-1:0] cfg_off;

   always_comb begin
      dec     = '0;
      dec.win = W_BAD;
      cfg_off = addr - ADDR_W'(12'hC00);
      if (addr < 12'h100) begin
         if (addr == 12'h000)      dec.win = W_GEN;
         else if (addr == 12'h004) dec.win = W_TYPE;
         else if (addr < 12'h008)  dec.win = W_ZERO;
      end else if (addr < 12'h200) begin
         dec.win  = W_EN;
         dec.clr  = addr[7];
         dec.base = IDX_W'({addr[6:0], 3'b000});
      end else if (addr < 12'h300) begin
         dec.win  = W_PEND;
         dec.clr  = addr[7];
         dec.base = IDX_W'({addr[6:0], 3'b000});
      end else if (addr < 12'h400) begin
         dec.win  = W_ACT;
         dec.base = IDX_W'({addr[7:0], 3'b000});
      end else if (addr < 12'h800) begin
         dec.win  = W_PRIO;
         dec.base = IDX_W'(addr[9:0]);
      end else if (addr < 12'hC00) begin
         dec.win  = W_TGT;
         dec.base = IDX_W'(addr[9:0]);
      end else if (addr < 12'hF00) begin
         dec.win  = W_CFG;
         dec.base = IDX_W'({cfg_off[9:0], 2'b00});
      end else if (addr >= 12'hFE0) begin
         if (addr[1:0] != 2'b00) dec.win = W_ZERO;
         else begin
            dec.win   = W_ID;
            dec.idsel = addr[4:2];
         end
      end
      if ((dec.win inside {W_EN, W_PEND, W_ACT, W_PRIO, W_TGT, W_CFG}) &&
          (dec.base >= IDX_W'(NUM_IRQ)))
         dec.win = W_BAD;
   end
endmodule

// File: rtl/irqd_bitfile.sv
module irqd_bitfile
   import irqd_pkg::*;
#(
   parameter int NUM_IRQ = 96
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic                clr,
   input  logic [IDX_W-1:0]    base,
   input  logic [7:0]          wdata,
   output logic [NUM_IRQ-1:0]  bits
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
      localparam logic [IDX_W-4:0] GRP = (IDX_W-3)'(i / 8);
      logic hit;
      assign hit = we && (base[IDX_W-1:3] == GRP) && wdata[i % 8];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   bits[i] <= 1'b0;
         else if (hit) bits[i] <= !clr;
      end
   end
endmodule

// File: rtl/irqd_active.sv
module irqd_active
   import irqd_pkg::*;
#(
   parameter int NUM_IRQ      = 96,
   parameter int NUM_CPU      = 2,
   parameter int NUM_INTERNAL = 32,
   localparam int CPU_W       = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CPU_W-1:0]   cpu_sel,
   input  logic               we,
   input  logic [IDX_W-1:0]   base,
   input  logic [7:0]         wdata,
   output logic [NUM_IRQ-1:0] view
);
   logic cpu_ok;
   assign cpu_ok = int'(cpu_sel) < NUM_CPU;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      localparam logic [IDX_W-4:0] GRP = (IDX_W-3)'(i / 8);
      logic hit;
      assign hit = we && (base[IDX_W-1:3] == GRP);
      if (i < NUM_INTERNAL) begin : g_banked
         logic [NUM_CPU-1:0] bank;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bank <= '0;
            else if (hit && cpu_ok) begin
               for (int c = 0; c < NUM_CPU; c++)
                  if (cpu_sel == CPU_W'(c)) bank[c] <= wdata[i % 8];
            end
         end
         assign view[i] = cpu_ok ? bank[cpu_sel] : 1'b0;
      end else begin : g_shared
         logic shared_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   shared_q <= 1'b0;
            else if (hit) shared_q <= wdata[i % 8];
         end
         assign view[i] = shared_q;
      end
   end
endmodule

// File: rtl/irqd_bytefile.sv
module irqd_bytefile
   import irqd_pkg::*;
#(
   parameter int NUM_IRQ = 96
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       wdata,
   output logic [7:0]       rbyte
);
   logic [7:0] store [NUM_IRQ];

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            store[i] <= '0;
         else if (we && idx == IDX_W'(i))       store[i] <= wdata;
      end
   end

   always_comb begin
      rbyte = '0;
      for (int i = 0; i < NUM_IRQ; i++)
         if (idx == IDX_W'(i)) rbyte = store[i];
   end
endmodule

// File: rtl/irq_dist_regbank.sv
module irq_dist_regbank
   import irqd_pkg::*;
#(
   parameter int          NUM_IRQ      = 96,
   parameter int          NUM_CPU      = 2,
   parameter int          NUM_INTERNAL = 32,
   parameter logic [63:0] ID_VALUE     = 64'hB1_05_F0_0D_00_00_13_90,
   localparam int         CPU_W        = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_W-1:0]  cpu_sel,
   input  logic              acc_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              err
);
   if (NUM_IRQ % 32 != 0 || NUM_IRQ < 32 || NUM_IRQ > 1024) begin : g_chk_irq
      $error("NUM_IRQ must be a multiple of 32 between 32 and 1024");
   end
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_chk_cpu
      $error("NUM_CPU must lie in 1..8");
   end
   if (NUM_INTERNAL < 0 || NUM_INTERNAL > NUM_IRQ) begin : g_chk_int
      $error("NUM_INTERNAL must not exceed NUM_IRQ");
   end

   localparam logic [7:0] TYPE_BYTE = 8'(NUM_IRQ / 32 - 1);

   dec_t dec;
   logic bad, wr_ok, rd_ok;
   logic gen_en_q;
   logic [NUM_IRQ-1:0] en_bits, pend_bits, act_view;
   logic [1:0] cfg_q [NUM_IRQ];
   logic [7:0] prio_byte, tgt_byte, rd_val;

   irqd_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (.addr(addr), .dec(dec));

   assign bad   = acc_en && (dec.win == W_BAD);
   assign wr_ok = acc_en && wr_en && (dec.win != W_BAD);
   assign rd_ok = acc_en && !wr_en && (dec.win != W_BAD);

   irqd_bitfile #(.NUM_IRQ(NUM_IRQ)) u_enable (
      .clk(clk), .rst_n(rst_n), .we(wr_ok && dec.win == W_EN), .clr(dec.clr),
      .base(dec.base), .wdata(wdata), .bits(en_bits));

   irqd_bitfile #(.NUM_IRQ(NUM_IRQ)) u_pending (
      .clk(clk), .rst_n(rst_n), .we(wr_ok && dec.win == W_PEND), .clr(dec.clr),
      .base(dec.base), .wdata(wdata), .bits(pend_bits));

   irqd_active #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .NUM_INTERNAL(NUM_INTERNAL)) u_active (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .we(wr_ok && dec.win == W_ACT),
      .base(dec.base), .wdata(wdata), .view(act_view));

   irqd_bytefile #(.NUM_IRQ(NUM_IRQ)) u_prio (
      .clk(clk), .rst_n(rst_n), .we(wr_ok && dec.win == W_PRIO),
      .idx(dec.base), .wdata(wdata), .rbyte(prio_byte));

   irqd_bytefile #(.NUM_IRQ(NUM_IRQ)) u_tgt (
      .clk(clk), .rst_n(rst_n), .we(wr_ok && dec.win == W_TGT),
      .idx(dec.base), .wdata(wdata), .rbyte(tgt_byte));

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cfg
      localparam logic [IDX_W-3:0] QUAD = (IDX_W-2)'(i / 4);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cfg_q[i] <= 2'b00;
         else if (wr_ok && dec.win == W_CFG && dec.base[IDX_W-1:2] == QUAD)
            cfg_q[i] <= wdata[2*(i%4) +: 2];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gen_en_q <= 1'b0;
      else if (wr_ok && dec.win == W_GEN) gen_en_q <= wdata[0];
   end

   function automatic logic [7:0] pick8(input logic [NUM_IRQ-1:0] vec,
                                        input logic [IDX_W-1:0] b);
      logic [7:0] r;
      r = '0;
      for (int k = 0; k < 8; k++)
         if (int'(b) + k < NUM_IRQ) r[k] = vec[int'(b) + k];
      return r;
   endfunction

   always_comb begin
      rd_val = '0;
      unique case (dec.win)
         W_GEN:  rd_val = {7'b0, gen_en_q};
         W_TYPE: rd_val = TYPE_BYTE;
         W_EN:   rd_val = pick8(en_bits, dec.base);
         W_PEND: rd_val = pick8(pend_bits, dec.base);
         W_ACT:  rd_val = pick8(act_view, dec.base);
         W_PRIO: rd_val = prio_byte;
         W_TGT:  rd_val = tgt_byte;
         W_CFG:
            for (int j = 0; j < 4; j++)
               if (int'(dec.base) + j < NUM_IRQ)
                  rd_val[2*j +: 2] = cfg_q[int'(dec.base) + j];
         W_ID:   rd_val = ID_VALUE[8*dec.idsel +: 8];
         default: rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         rdata <= rd_ok ? rd_val : 8'h00;
         err   <= bad;
      end
   end
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
   parameter int NUM_IRQ = 96
) (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_en,
   input logic        wr_en,
   input logic [11:0] addr,
   input logic [7:0]  rdata,
   input logic        err
);
   a_r8_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> rdata == 8'h00);

   a_r10_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(acc_en) |-> !err);

   a_r10_write_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(acc_en && wr_en) |-> rdata == 8'h00);

   a_r2_type_byte: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(acc_en && !wr_en && addr == 12'h004)
         |-> rdata == 8'(NUM_IRQ / 32 - 1) && !err);

   a_r8_gap_error: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(acc_en && addr >= 12'hF00 && addr < 12'hFE0) |-> err);

   a_r9_unaligned_id: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(acc_en && addr >= 12'hFE0 && addr[1:0] != 2'b00)
         |-> rdata == 8'h00 && !err);
endmodule

bind irq_dist_regbank irqd_checker #(.NUM_IRQ(NUM_IRQ)) u_irqd_checker (
   .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en),
   .addr(addr), .rdata(rdata), .err(err));

// File: tb/irq_dist_regbank_bench.sv
module irq_dist_regbank_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 96;
   localparam int NC = 2;
   localparam int NI = 32;
   localparam logic [63:0] IDV = 64'hB1_05_F0_0D_00_00_13_90;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [0:0] cpu_sel = '0;
   logic       acc_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       err;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   bit       m_gen;
   bit       m_bits [2][N];
   bit       m_bank [NC][NI];
   bit       m_sh   [N];
   bit [7:0] m_prio [N];
   bit [7:0] m_tgt  [N];
   bit [1:0] m_cfg  [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_dist_regbank #(.NUM_IRQ(N), .NUM_CPU(NC), .NUM_INTERNAL(NI), .ID_VALUE(IDV))
      u_irq_dist_regbank (.clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .acc_en(acc_en),
                          .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .err(err));

   function automatic string tag_of(input int a, input bit e);
      if (e)            return "R8";
      if (a < 'h100)    return "R2";
      if (a < 'h200)    return "R3";
      if (a < 'h300)    return "R4";
      if (a < 'h400)    return "R5";
      if (a < 'hC00)    return "R6";
      if (a < 'hF00)    return "R7";
      return "R9";
   endfunction

   task automatic model(input bit wr, input int a, input bit [7:0] d, input int c,
                        output bit [7:0] r, output bit e);
      int irq, sel;
      bit clr;
      r = 0; e = 0;
      if (a < 'h100) begin
         if (a == 0) begin if (wr) m_gen = d[0]; else r = {7'b0, m_gen}; end
         else if (a == 4) begin if (!wr) r = 8'(N/32 - 1); end
         else if (a >= 8) e = 1;
      end else if (a < 'h300) begin
         sel = (a < 'h200) ? 0 : 1;
         irq = (a % 128) * 8;
         clr = (a % 256) >= 128;
         if (irq >= N) e = 1;
         else for (int i = 0; i < 8; i++) begin
            if (wr) begin if (d[i]) m_bits[sel][irq+i] = !clr; end
            else r[i] = m_bits[sel][irq+i];
         end
      end else if (a < 'h400) begin
         irq = (a - 'h300) * 8;
         if (irq >= N) e = 1;
         else for (int i = 0; i < 8; i++) begin
            if (irq + i < NI) begin
               if (wr) m_bank[c][irq+i] = d[i]; else r[i] = m_bank[c][irq+i];
            end else begin
               if (wr) m_sh[irq+i] = d[i]; else r[i] = m_sh[irq+i];
            end
         end
      end else if (a < 'h800) begin
         irq = a - 'h400;
         if (irq >= N) e = 1; else if (wr) m_prio[irq] = d; else r = m_prio[irq];
      end else if (a < 'hC00) begin
         irq = a - 'h800;
         if (irq >= N) e = 1; else if (wr) m_tgt[irq] = d; else r = m_tgt[irq];
      end else if (a < 'hF00) begin
         irq = (a - 'hC00) * 4;
         if (irq >= N) e = 1;
         else for (int j = 0; j < 4; j++) begin
            if (wr) m_cfg[irq+j] = d[2*j +: 2]; else r[2*j +: 2] = m_cfg[irq+j];
         end
      end else if (a < 'hFE0) e = 1;
      else if (a % 4 == 0 && !wr) r = IDV[8*((a - 'hFE0)/4) +: 8];
      if (e || wr) r = 0;
   endtask

   task automatic check(input string tag, input bit [7:0] er, input bit ee);
      checks++;
      if (rdata !== er || err !== ee) begin
         fails++;
         $display("FAIL %s: rdata=%02h err=%0b expected rdata=%02h err=%0b",
                  tag, rdata, err, er, ee);
      end
   endtask

   // called at a falling edge; returns at the next falling edge after checking
   task automatic access(input bit wr, input int a, input bit [7:0] d, input int c,
                         input string tag_over = "");
      bit [7:0] er; bit ee;
      acc_en = 1; wr_en = wr; addr = 12'(a); wdata = d; cpu_sel = 1'(c);
      model(wr, a, d, c, er, ee);
      @(negedge clk);
      acc_en = 0; wr_en = 0;
      check(tag_over != "" ? tag_over : tag_of(a, ee), er, ee);
   endtask

   task automatic idle();
      acc_en = 0; wr_en = 0;
      @(negedge clk);
      check("R10", 8'h00, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", 8'h00, 1'b0);
      rst_n = 1;
      @(negedge clk);
      // R1: reset values
      foreach (m_prio[i]) begin m_prio[i] = 0; m_tgt[i] = 0; m_cfg[i] = 0; m_sh[i] = 0; end
      access(0, 'h000, 0, 0, "R1");
      access(0, 'h100, 0, 0, "R1");
      access(0, 'h30B, 0, 1, "R1");
      access(0, 'h45F, 0, 0, "R1");
      access(0, 'hC17, 0, 0, "R1");
      idle();
      // R2: control region
      access(1, 'h000, 8'hFF, 0);
      access(0, 'h000, 0, 0);
      access(0, 'h004, 0, 0);
      access(1, 'h005, 8'hAA, 0);
      access(0, 'h005, 0, 0);
      access(0, 'h003, 0, 0);
      access(0, 'h008, 0, 0);
      access(0, 'h0FF, 0, 0);
      access(1, 'h000, 8'h02, 0);
      access(0, 'h000, 0, 0);
      // R3: enable set and clear through aliasing windows
      access(1, 'h100, 8'hA5, 0);
      access(0, 'h180, 0, 0);
      access(1, 'h10B, 8'h81, 0);
      access(0, 'h10B, 0, 0);
      access(1, 'h180, 8'h05, 0);
      access(0, 'h100, 0, 0);
      access(1, 'h100, 8'h00, 0);
      access(0, 'h180, 0, 0);
      access(0, 'h10C, 0, 0);
      access(1, 'h18C, 8'hFF, 0);
      // R4: pending
      access(1, 'h201, 8'h3C, 0);
      access(0, 'h281, 0, 0);
      access(1, 'h281, 8'h14, 0);
      access(0, 'h201, 0, 0);
      access(0, 'h101, 0, 0);
      access(0, 'h20C, 0, 0);
      // R5: banked active
      access(1, 'h300, 8'hF0, 0);
      access(0, 'h300, 0, 1);
      access(1, 'h300, 8'h0F, 1);
      access(0, 'h300, 0, 0);
      access(0, 'h300, 0, 1);
      access(1, 'h304, 8'h99, 0);
      access(0, 'h304, 0, 1);
      access(1, 'h30B, 8'h80, 1);
      access(0, 'h30B, 0, 0);
      access(0, 'h30C, 0, 0);
      // R6: priority and target
      access(1, 'h400, 8'h12, 0);
      access(1, 'h45F, 8'hFE, 0);
      access(1, 'h800, 8'h03, 0);
      access(1, 'h85F, 8'h02, 0);
      access(0, 'h400, 0, 0);
      access(0, 'h45F, 0, 0);
      access(0, 'h800, 0, 0);
      access(0, 'h85F, 0, 0);
      access(1, 'h460, 8'h77, 0);
      access(0, 'h860, 0, 0);
      // R7: configuration
      access(1, 'hC00, 8'b10_01_11_00, 0);
      access(0, 'hC00, 0, 0);
      access(1, 'hC17, 8'h6C, 0);
      access(0, 'hC17, 0, 0);
      access(0, 'hC18, 0, 0);
      access(0, 'hEFF, 0, 0);
      // R8: gap region
      access(0, 'hF00, 0, 0);
      access(1, 'hFDF, 8'h11, 0);
      idle();
      // R9: identification
      for (int k = 0; k < 8; k++) access(0, 'hFE0 + 4*k, 0, 0);
      access(0, 'hFE1, 0, 0);
      access(0, 'hFFF, 0, 0);
      access(1, 'hFE4, 8'h55, 0);
      access(0, 'hFE4, 0, 0);
      // R10: back-to-back errors then a read
      access(0, 'h0F0, 0, 0);
      access(0, 'hF10, 0, 0);
      access(0, 'h004, 0, 0);
      idle();
      // mixed traffic
      for (int n = 0; n < 3000; n++) begin
         int a, sel;
         sel = int'($urandom_range(0, 9));
         case (sel)
            0: a = int'($urandom_range(0, 'h00F));
            1: a = int'($urandom_range('h100, 'h10D));
            2: a = int'($urandom_range('h180, 'h18D));
            3: a = int'($urandom_range('h200, 'h28D));
            4: a = int'($urandom_range('h300, 'h30D));
            5: a = int'($urandom_range('h400, 'h462));
            6: a = int'($urandom_range('h800, 'h862));
            7: a = int'($urandom_range('hC00, 'hC19));
            8: a = int'($urandom_range('hEF0, 'hFFF));
            default: a = int'($urandom_range(0, 'hFFF));
         endcase
         if ($urandom_range(0, 7) == 0) idle();
         access(1'($urandom_range(0, 1)), a, 8'($urandom), int'($urandom_range(0, NC-1)));
      end
      idle();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule